// File: doc/BRIEF.md
# Operand Stack Register Cache Controller

This block tracks which of four general registers hold the topmost entries of a stack machine's operand stack. The four registers form a rotating window. A head index names the register that holds the top of stack, and an occupancy count says how many of the four registers are live. Values never move between registers: a push advances the head and a pop steps it back. The instruction translator reads the top-of-stack and next-of-stack register indexes so that the instructions it generates name the correct physical registers.

A push to a full window first stores the oldest live register to memory. A pop from an empty window first loads the most recent memory entry back into the head register. Both memory requests are built from a stack base pointer supplied by the surrounding logic, plus a count of the entries the block has already moved to memory. A request that needs a memory transfer stalls the translator until the memory side accepts it. The branch logic can ask for a flush. The block then writes back every live register, oldest first, at one store per accepted cycle, and signals completion with a single-cycle pulse.

Top module: `stack_cache_ctrl`

## Requirements
- R1: After reset the occupancy is 0, the top-of-stack index is 0, the next-of-stack index is 3, no memory request is raised and the flush-busy and flush-done outputs are low.
- R2: A push (reqOp 2'b01) with occupancy below 4 is accepted in the same cycle. After the clock edge the occupancy is one higher, the top-of-stack index is the old one plus 1 modulo 4, and the next-of-stack index equals the old top-of-stack index.
- R3: A pop (reqOp 2'b10) with occupancy above 0 is accepted in the same cycle. After the edge the occupancy is one lower and the top-of-stack index is the old one minus 1 modulo 4.
- R4: A push with occupancy 4 raises a store (memValid=1, memWrite=1). The store names register (top index + 1) mod 4 and the address stackBase + 4 × (entries already in memory). reqReady follows memReady, and nothing changes while memReady is low. On acceptance the occupancy stays 4 and the top index advances by 1.
- R5: A pop with occupancy 0 and at least one entry in memory raises a load (memValid=1, memWrite=0) into the top-of-stack register, at stackBase + 4 × (entries in memory − 1). On acceptance the occupancy stays 0 and the top index drops by 1.
- R6: A pop with occupancy 0 and no entries in memory is accepted at once, raises no memory request and changes no state.
- R7: The request codes 2'b00 and 2'b11 are accepted at once and change no state.
- R8: A flush pulse raises flushBusy from the next cycle, and reqReady is held low while flushBusy is high. The block stores one live register per accepted cycle, oldest first, at addresses rising by 4. Once the occupancy reaches 0, flushBusy falls and flushDone is high for exactly one cycle. The top-of-stack index is left unchanged.
- R9: A flush request takes priority over a request presented in the same cycle, which is not accepted.
- R10: A flush with occupancy 0 keeps flushBusy high for one cycle, raises no memory request, and then pulses flushDone.
- R11: While a flush store waits for memReady, its register index and address hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translator request present |
| reqOp | input | 2 | Request code: 01 push, 10 pop, others no-op |
| reqReady | output | 1 | Request accepted this cycle |
| flushReq | input | 1 | Flush pulse from branch logic |
| flushBusy | output | 1 | Flush in progress |
| flushDone | output | 1 | One-cycle flush completion pulse |
| tosReg | output | 2 | Register index holding top of stack |
| nosReg | output | 2 | Register index holding next of stack |
| count | output | 3 | Live entries in the register window (0..4) |
| stackBase | input | 32 | In-memory stack base pointer |
| memValid | output | 1 | Spill or fill request |
| memWrite | output | 1 | 1 store (spill), 0 load (fill) |
| memReg | output | 2 | Register the transfer reads or writes |
| memAddr | output | 32 | Byte address of the transfer |
| memReady | input | 1 | Memory side accepts the request |

## Verification
The hardest state to reach is a flush that runs from a full window after earlier spills have already moved the head away from register 0 and left entries in memory. Only in that state do the oldest-first ordering, the wraparound of register indexes and the running address offset all show up together. The stimulus fills the window, spills twice, once under a held-off memReady, and then raises a flush together with a competing push. It stalls the first flush store for a cycle and finally pops from the empty window, so that a fill must come back from the far end of the flushed entries.

// File: rtl/stack_cache_pkg.sv
package stack_cache_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_RSVD = 2'b11
  } stack_op_e;

  // Strobes from control to datapath, one per state change
  typedef struct packed {
    logic headInc;
    logic headDec;
    logic countInc;
    logic countDec;
    logic depthInc;
    logic depthDec;
    logic selFill;
  } dp_strobe_t;

endpackage

// File: rtl/stack_cache_dp.sv
module stack_cache_dp
  import stack_cache_pkg::*;
#(
  parameter int NUM_REGS   = 4,
  parameter int ADDR_W     = 32,
  parameter int DEPTH_W    = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  dp_strobe_t                    strobe,
  input  logic [ADDR_W-1:0]             stackBase,
  output logic [$clog2(NUM_REGS)-1:0]   tosReg,
  output logic [$clog2(NUM_REGS)-1:0]   nosReg,
  output logic [$clog2(NUM_REGS+1)-1:0] count,
  output logic                          cacheFull,
  output logic                          cacheEmpty,
  output logic                          depthZero,
  output logic [$clog2(NUM_REGS)-1:0]   memReg,
  output logic [ADDR_W-1:0]             memAddr
);
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int CNT_W      = $clog2(NUM_REGS + 1);
  localparam int BYTE_SHIFT = $clog2(WORD_BYTES);

  logic [IDX_W-1:0]   headQ;
  logic [CNT_W-1:0]   countQ;
  logic [DEPTH_W-1:0] depthQ;
  logic [IDX_W-1:0]   oldestIdx;
  logic [DEPTH_W-1:0] depthSel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headQ  <= '0;
      countQ <= '0;
      depthQ <= '0;
    end else begin
      if (strobe.headInc)       headQ <= headQ + IDX_W'(1);
      else if (strobe.headDec)  headQ <= headQ - IDX_W'(1);
      if (strobe.countInc)      countQ <= countQ + CNT_W'(1);
      else if (strobe.countDec) countQ <= countQ - CNT_W'(1);
      if (strobe.depthInc)      depthQ <= depthQ + DEPTH_W'(1);
      else if (strobe.depthDec) depthQ <= depthQ - DEPTH_W'(1);
    end
  end

  // Oldest live register: head - count + 1, modulo the window size
  assign oldestIdx  = headQ + IDX_W'(1) - countQ[IDX_W-1:0];
  assign depthSel   = strobe.selFill ? depthQ - DEPTH_W'(1) : depthQ;

  assign tosReg     = headQ;
  assign nosReg     = headQ - IDX_W'(1);
  assign count      = countQ;
  assign cacheFull  = (countQ == CNT_W'(NUM_REGS));
  assign cacheEmpty = (countQ == '0);
  assign depthZero  = (depthQ == '0);
  assign memReg     = strobe.selFill ? headQ : oldestIdx;
  assign memAddr    = stackBase + (ADDR_W'(depthSel) << BYTE_SHIFT);

endmodule

// File: rtl/stack_cache_ctl.sv
module stack_cache_ctl
  import stack_cache_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       flushReq,
  input  logic       memReady,
  input  logic       cacheFull,
  input  logic       cacheEmpty,
  input  logic       depthZero,
  output logic       reqReady,
  output logic       memValid,
  output logic       memWrite,
  output logic       flushBusy,
  output logic       flushDone,
  output dp_strobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_FLUSH} ctl_state_e;

  ctl_state_e stateQ, stateNext;
  logic       doneNext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ    <= ST_IDLE;
      flushDone <= 1'b0;
    end else begin
      stateQ    <= stateNext;
      flushDone <= doneNext;
    end
  end

  always_comb begin
    strobe    = '0;
    reqReady  = 1'b0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    stateNext = stateQ;
    doneNext  = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (flushReq) begin
          stateNext = ST_FLUSH;
        end else if (reqValid) begin
          case (stack_op_e'(reqOp))
            OP_PUSH: begin
              if (cacheFull) begin
                memValid = 1'b1;
                memWrite = 1'b1;
                reqReady = memReady;
                strobe.headInc  = memReady;
                strobe.depthInc = memReady;
              end else begin
                reqReady = 1'b1;
                strobe.headInc  = 1'b1;
                strobe.countInc = 1'b1;
              end
            end
            OP_POP: begin
              if (!cacheEmpty) begin
                reqReady = 1'b1;
                strobe.headDec  = 1'b1;
                strobe.countDec = 1'b1;
              end else if (depthZero) begin
                reqReady = 1'b1;
              end else begin
                strobe.selFill  = 1'b1;
                memValid = 1'b1;
                reqReady = memReady;
                strobe.headDec  = memReady;
                strobe.depthDec = memReady;
              end
            end
            default: reqReady = 1'b1;
          endcase
        end
      end
      ST_FLUSH: begin
        if (!cacheEmpty) begin
          memValid = 1'b1;
          memWrite = 1'b1;
          strobe.countDec = memReady;
          strobe.depthInc = memReady;
        end else begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign flushBusy = (stateQ == ST_FLUSH);

endmodule

// File: rtl/stack_cache_ctrl.sv
module stack_cache_ctrl
  import stack_cache_pkg::*;
#(
  parameter int NUM_REGS   = 4,
  parameter int ADDR_W     = 32,
  parameter int DEPTH_W    = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int CNT_W     = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  output logic              reqReady,
  input  logic              flushReq,
  output logic              flushBusy,
  output logic              flushDone,
  output logic [IDX_W-1:0]  tosReg,
  output logic [IDX_W-1:0]  nosReg,
  output logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] stackBase,
  output logic              memValid,
  output logic              memWrite,
  output logic [IDX_W-1:0]  memReg,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memReady
);
  dp_strobe_t strobe;
  logic       cacheFull, cacheEmpty, depthZero;

  stack_cache_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .flushReq   (flushReq),
    .memReady   (memReady),
    .cacheFull  (cacheFull),
    .cacheEmpty (cacheEmpty),
    .depthZero  (depthZero),
    .reqReady   (reqReady),
    .memValid   (memValid),
    .memWrite   (memWrite),
    .flushBusy  (flushBusy),
    .flushDone  (flushDone),
    .strobe     (strobe)
  );

  stack_cache_dp #(
    .NUM_REGS   (NUM_REGS),
    .ADDR_W     (ADDR_W),
    .DEPTH_W    (DEPTH_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .stackBase  (stackBase),
    .tosReg     (tosReg),
    .nosReg     (nosReg),
    .count      (count),
    .cacheFull  (cacheFull),
    .cacheEmpty (cacheEmpty),
    .depthZero  (depthZero),
    .memReg     (memReg),
    .memAddr    (memAddr)
  );

endmodule

// File: rtl/stack_cache_ctrl_chk.sv
module stack_cache_ctrl_chk #(
  parameter int IDX_W    = 2,
  parameter int CNT_W    = 3,
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic [1:0]        reqOp,
  input logic              reqReady,
  input logic              flushReq,
  input logic              flushBusy,
  input logic              flushDone,
  input logic [IDX_W-1:0]  tosReg,
  input logic [IDX_W-1:0]  nosReg,
  input logic [CNT_W-1:0]  count,
  input logic              memValid,
  input logic              memWrite,
  input logic [IDX_W-1:0]  memReg,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memReady
);
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(NUM_REGS)); // R2

  AST_NOS_BELOW_TOS: assert property (@(posedge clk) disable iff (!rst_n)
    nosReg == IDX_W'(tosReg - 1'b1)); // R2

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady && reqOp == 2'b01 && !memValid |=>
      count == CNT_W'($past(count) + 1'b1) && tosReg == IDX_W'($past(tosReg) + 1'b1)); // R2

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady && reqOp == 2'b10 && !memValid && $past(count) != '0 |=>
      count == CNT_W'($past(count) - 1'b1)); // R3

  AST_SPILL_REG: assert property (@(posedge clk) disable iff (!rst_n)
    memValid && memWrite && !flushBusy |-> memReg == IDX_W'(tosReg + 1'b1)); // R4

  AST_FILL_REG: assert property (@(posedge clk) disable iff (!rst_n)
    memValid && !memWrite |-> memReg == tosReg && count == '0); // R5

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    flushBusy |-> !reqReady); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flushDone |=> !flushDone); // R8

  AST_FLUSH_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq && !flushBusy |-> !reqReady); // R9

  AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flushBusy && memValid && !memReady |=>
      memValid && $stable(memAddr) && $stable(memReg)); // R11

endmodule

bind stack_cache_ctrl stack_cache_ctrl_chk #(
  .IDX_W    (IDX_W),
  .CNT_W    (CNT_W),
  .ADDR_W   (ADDR_W),
  .NUM_REGS (NUM_REGS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqOp     (reqOp),
  .reqReady  (reqReady),
  .flushReq  (flushReq),
  .flushBusy (flushBusy),
  .flushDone (flushDone),
  .tosReg    (tosReg),
  .nosReg    (nosReg),
  .count     (count),
  .memValid  (memValid),
  .memWrite  (memWrite),
  .memReg    (memReg),
  .memAddr   (memAddr),
  .memReady  (memReady)
);

// File: tb/stack_cache_ctrl_tb.sv
module stack_cache_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reqValid, flushReq, memReady;
  logic [1:0]  reqOp;
  logic        reqReady, flushBusy, flushDone, memValid, memWrite;
  logic [1:0]  tosReg, nosReg, memReg;
  logic [2:0]  count;
  logic [31:0] memAddr;

  int  nRun  = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_cache_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqReady(reqReady),
    .flushReq(flushReq), .flushBusy(flushBusy), .flushDone(flushDone),
    .tosReg(tosReg), .nosReg(nosReg), .count(count), .stackBase(BASE),
    .memValid(memValid), .memWrite(memWrite), .memReg(memReg), .memAddr(memAddr),
    .memReady(memReady)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        mv;
    logic        mw;
    logic [1:0]  mreg;
    logic [31:0] addr;
    logic [2:0]  cnt;
    logic [1:0]  tos;
  } vec_t;

  // op, memValid, memWrite, memReg, memAddr (if valid), count after, tos after
  localparam vec_t VEC [13] = '{
    '{2'b01, 1'b0, 1'b0, 2'd0, 32'h0,    3'd1, 2'd1},  // R2
    '{2'b01, 1'b0, 1'b0, 2'd0, 32'h0,    3'd2, 2'd2},  // R2
    '{2'b01, 1'b0, 1'b0, 2'd0, 32'h0,    3'd3, 2'd3},  // R2
    '{2'b01, 1'b0, 1'b0, 2'd0, 32'h0,    3'd4, 2'd0},  // R2 wrap
    '{2'b01, 1'b1, 1'b1, 2'd1, 32'h1000, 3'd4, 2'd1},  // R4 spill
    '{2'b10, 1'b0, 1'b0, 2'd0, 32'h0,    3'd3, 2'd0},  // R3
    '{2'b00, 1'b0, 1'b0, 2'd0, 32'h0,    3'd3, 2'd0},  // R7
    '{2'b10, 1'b0, 1'b0, 2'd0, 32'h0,    3'd2, 2'd3},  // R3 wrap
    '{2'b10, 1'b0, 1'b0, 2'd0, 32'h0,    3'd1, 2'd2},  // R3
    '{2'b10, 1'b0, 1'b0, 2'd0, 32'h0,    3'd0, 2'd1},  // R3
    '{2'b10, 1'b1, 1'b0, 2'd1, 32'h1000, 3'd0, 2'd0},  // R5 fill
    '{2'b10, 1'b0, 1'b0, 2'd0, 32'h0,    3'd0, 2'd0},  // R6
    '{2'b11, 1'b0, 1'b0, 2'd0, 32'h0,    3'd0, 2'd0}   // R7
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // packs {memValid, memWrite, memReg, memAddr}
  function automatic logic [35:0] memView();
    return {memValid, memWrite, memReg, memAddr};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reqValid = 1'b0; reqOp = 2'b00; flushReq = 1'b0; memReady = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(count == 3'd0 && tosReg == 2'd0 && nosReg == 2'd3 && !memValid && !flushBusy && !flushDone,
        "R1 reset", {count, tosReg, nosReg, memValid, flushBusy, flushDone}, {3'd0, 2'd0, 2'd3, 3'b000});

    // table walk, memReady held high
    for (int i = 0; i < 13; i++) begin
      reqValid = 1'b1; reqOp = VEC[i].op;
      #1;
      chk(reqReady && memValid == VEC[i].mv &&
          (!VEC[i].mv || (memWrite == VEC[i].mw && memReg == VEC[i].mreg && memAddr == VEC[i].addr)),
          "R2-step mem/ready (R4 R5 R6 R7)", {reqReady, memView()}, {1'b1, VEC[i].mv, VEC[i].mw, VEC[i].mreg, VEC[i].addr});
      tick();
      reqValid = 1'b0;
      #1;
      chk(count == VEC[i].cnt && tosReg == VEC[i].tos && nosReg == 2'(VEC[i].tos - 1'b1),
          "R2/R3 state after step", {count, tosReg, nosReg}, {VEC[i].cnt, VEC[i].tos, 2'(VEC[i].tos - 1'b1)});
    end

    // refill to four: head 0 -> regs 1,2,3,0
    for (int i = 0; i < 4; i++) begin
      reqValid = 1'b1; reqOp = 2'b01; tick();
    end
    reqValid = 1'b0; #1;
    chk(count == 3'd4 && tosReg == 2'd0, "R2 refill", {count, tosReg}, {3'd4, 2'd0});

    // R4 stalled spill
    memReady = 1'b0; reqValid = 1'b1; reqOp = 2'b01;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(!reqReady && memValid && memWrite && memReg == 2'd1 && memAddr == 32'h1000,
          "R4 stalled spill", {reqReady, memView()}, {1'b0, 1'b1, 1'b1, 2'd1, 32'h1000});
      tick();
      chk(count == 3'd4 && tosReg == 2'd0, "R4 no change while stalled", {count, tosReg}, {3'd4, 2'd0});
    end
    memReady = 1'b1; #1;
    chk(reqReady, "R4 ready follows memReady", reqReady, 1);
    tick();
    chk(count == 3'd4 && tosReg == 2'd1, "R4 after accept", {count, tosReg}, {3'd4, 2'd1});
    #1;
    chk(memValid && memReg == 2'd2 && memAddr == 32'h1004, "R4 second spill", memView(), {1'b1, 1'b1, 2'd2, 32'h1004});
    tick();
    reqValid = 1'b0; #1;
    chk(count == 3'd4 && tosReg == 2'd2, "R4 second accept", {count, tosReg}, {3'd4, 2'd2});

    // R9 flush beats a push in the same cycle
    flushReq = 1'b1; reqValid = 1'b1; reqOp = 2'b01; #1;
    chk(!reqReady, "R9 flush priority", reqReady, 0);
    tick();
    flushReq = 1'b0; reqValid = 1'b0;
    chk(count == 3'd4 && flushBusy, "R9 push not taken", {count, flushBusy}, {3'd4, 1'b1});

    // R11 first flush store held off
    memReady = 1'b0; #1;
    chk(memValid && memWrite && memReg == 2'd3 && memAddr == 32'h1008, "R8 oldest first", memView(), {1'b1, 1'b1, 2'd3, 32'h1008});
    tick();
    chk(memValid && memReg == 2'd3 && memAddr == 32'h1008 && count == 3'd4, "R11 hold", {memView(), count}, {1'b1, 1'b1, 2'd3, 32'h1008, 3'd4});
    memReady = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(flushBusy && !reqReady && memValid && memWrite && memReg == 2'(3 + i) &&
          memAddr == BASE + 32'(8 + 4*i), "R8 flush order", memView(),
          {1'b1, 1'b1, 2'(3 + i), BASE + 32'(8 + 4*i)});
      tick();
    end
    chk(flushBusy && !memValid && count == 3'd0 && !flushDone, "R8 drained", {flushBusy, memValid, count, flushDone}, {1'b1, 1'b0, 3'd0, 1'b0});
    tick();
    chk(flushDone && !flushBusy && tosReg == 2'd2, "R8 done pulse", {flushDone, flushBusy, tosReg}, {1'b1, 1'b0, 2'd2});
    tick();
    chk(!flushDone, "R8 done one cycle", flushDone, 0);

    // R10 flush of an empty window
    flushReq = 1'b1; tick(); flushReq = 1'b0;
    chk(flushBusy && !memValid, "R10 busy no store", {flushBusy, memValid}, {1'b1, 1'b0});
    tick();
    chk(flushDone && !flushBusy, "R10 done", {flushDone, flushBusy}, {1'b1, 1'b0});

    // R5 fill of the last flushed entry (six in memory)
    reqValid = 1'b1; reqOp = 2'b10; #1;
    chk(reqReady && memValid && !memWrite && memReg == 2'd2 && memAddr == 32'h1014,
        "R5 fill after flush", {reqReady, memView()}, {1'b1, 1'b1, 1'b0, 2'd2, 32'h1014});
    tick(); reqValid = 1'b0;
    chk(count == 3'd0 && tosReg == 2'd1, "R5 after fill", {count, tosReg}, {3'd0, 2'd1});

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule